// File: doc/BRIEF.md
# Pattern-Table Bank Translator with RAM Override

This block sits between the picture-fetch address bus of a cartridge-style banking controller and its pattern storage. It takes a 13-bit pattern address and turns it into an 18-bit bank index in 1 KB units plus a 10-bit offset within that bank. Four banking styles are supported, selected by a 2-bit mode: an externally computed inner bank, a serially loaded pair of 5-bit registers that work either as one 8 KB bank or two 4 KB halves, a flat unbanked window, and a 2-bit fixed-granularity bank in 8 KB units. Three outer bits are shared by all modes and form the top of the bank index.

A single enable bit redirects the whole pattern space to an internal 8 KB RAM. While it is set, reads and writes go to that RAM and the ROM-side strobes stay quiet. While it is clear, reads are handed to ROM with the translated bank, and writes are passed on to the external controller and leave the RAM untouched. RAM writes are synchronous, and RAM read data appears one clock after the read request.

Top module: `chr_bank_xlat`

## Requirements
- R1: While `ram_en` is 1, `rom_rd` and `ext_wr` are 0 whatever `rd` and `wr` do.
- R2: While `ram_en` is 1, a write stores `wdata` at the RAM location `addr[12:0]` on the clock edge; a read loads that location into `rdata`, which is valid from the next edge on. A read and a write to the same location in one cycle return the old contents. `rdata` holds its value in every cycle without a RAM read.
- R3: In every mode, `bank[17:15]` equals `{outer_top, outer_b, outer_a}`.
- R4: With `mode` = 0, `bank[14:0]` equals `m0_bank`, zero extended.
- R5: With `mode` = 1 and `ser_4kb` = 0, `bank[14:0]` equals `(ser_bank0 & 5'h1E) * 4 + addr[12:10]`; bit 0 of `ser_bank0` has no effect.
- R6: With `mode` = 1 and `ser_4kb` = 1, `bank[14:0]` equals `reg * 4 + addr[11:10]`, where `reg` is `ser_bank0` when `addr[12]` is 0 and `ser_bank1` when it is 1.
- R7: With `mode` = 2, `bank[14:0]` equals `addr[12:10]`.
- R8: With `mode` = 3, `bank[14:0]` equals `fix_bank * 8 + addr[12:10]`, so the full index is `(outer8k | fix_bank) * 8 + addr[12:10]` with `outer8k = top<<14 | b<<13 | a<<12`.
- R9: In every mode `offset` equals `addr[9:0]`.
- R10: While `ram_en` is 0, `rom_rd` follows `rd`, `ext_wr` follows `wr`, and a write leaves the RAM contents unchanged.
- R11: While `rst_n` is low and after its release, `rdata` is 0 until the first RAM read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Banking style: 0 external, 1 serial pair, 2 flat, 3 fixed 8 KB |
| ram_en | input | 1 | Redirect all pattern accesses to the internal RAM |
| outer_a | input | 1 | Outer bit, weight 2^15 in 1 KB units |
| outer_b | input | 1 | Outer bit, weight 2^16 in 1 KB units |
| outer_top | input | 1 | Outer bit, weight 2^17 in 1 KB units |
| m0_bank | input | M0_W | Inner 1 KB bank for mode 0 |
| ser_4kb | input | 1 | Mode 1 granularity: 0 one 8 KB bank, 1 two 4 KB halves |
| ser_bank0 | input | 5 | Mode 1 first bank register (4 KB units) |
| ser_bank1 | input | 5 | Mode 1 second bank register (4 KB units) |
| fix_bank | input | 2 | Mode 3 bank in 8 KB units |
| addr | input | 13 | Pattern address |
| rd | input | 1 | Read request |
| wr | input | 1 | Write request |
| wdata | input | DATA_W | Write data |
| bank | output | 18 | Translated 1 KB bank index |
| offset | output | 10 | Offset within the 1 KB bank |
| rom_rd | output | 1 | Read forwarded to ROM |
| ext_wr | output | 1 | Write forwarded to the external controller |
| rdata | output | DATA_W | Registered RAM read data |

## Verification
A wrong mode decode or a misplaced field shows on `bank` in the same cycle the address is presented, since translation is purely combinational; comparing every cycle across all modes, both serial granularities and all eight address windows exposes it at once. Corrupted RAM state, such as a write that lands while the override is off or a write-before-read ordering, only appears one clock after a later read of the same location, so the stimulus writes, overwrites and reads back chosen locations including both ends of the RAM.

// File: rtl/chr_bank_xlat.sv
module chr_bank_xlat #(
  parameter int DATA_W = 8,
  parameter int M0_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              ram_en,
  input  logic              outer_a,
  input  logic              outer_b,
  input  logic              outer_top,
  input  logic [M0_W-1:0]   m0_bank,
  input  logic              ser_4kb,
  input  logic [4:0]        ser_bank0,
  input  logic [4:0]        ser_bank1,
  input  logic [1:0]        fix_bank,
  input  logic [12:0]       addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [17:0]       bank,
  output logic [9:0]        offset,
  output logic              rom_rd,
  output logic              ext_wr,
  output logic [DATA_W-1:0] rdata
);
  localparam int ADDR_W  = 13;
  localparam int OFS_W   = 10;
  localparam int BANK_W  = 18;
  localparam int INNER_W = BANK_W - 3;
  localparam int DEPTH   = 1 << ADDR_W;

  logic [INNER_W-1:0] inner;
  logic [4:0]         ser_pick;
  logic [DATA_W-1:0]  mem [DEPTH];

  assign ser_pick = addr[12] ? ser_bank1 : ser_bank0;

  always_comb begin
    case (mode)
      2'd0:    inner = INNER_W'(m0_bank);
      2'd1:    inner = ser_4kb ? INNER_W'({ser_pick, addr[11:10]})
                               : INNER_W'({ser_bank0[4:1], addr[12:10]});
      2'd2:    inner = INNER_W'(addr[12:10]);
      default: inner = INNER_W'({fix_bank, addr[12:10]});
    endcase
  end

  assign bank   = {outer_top, outer_b, outer_a, inner};
  assign offset = addr[OFS_W-1:0];
  assign rom_rd = rd & ~ram_en;
  assign ext_wr = wr & ~ram_en;

  always_ff @(posedge clk) begin
    if (wr && ram_en) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rdata <= '0;
    else if (rd && ram_en)  rdata <= mem[addr];
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && ram_en) |=> $stable(rdata)); // R2

  AST_RAM_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ram_en && !rd) ##1 (rd && ram_en && !wr && addr == $past(addr))
    |=> rdata == $past(wdata, 2)); // R2

  AST_SER8K_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !ser_4kb) |-> (bank[2:0] == addr[12:10] && bank[6:3] == ser_bank0[4:1])); // R5

  AST_SER4K_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && ser_4kb) |-> (bank[1:0] == addr[11:10])); // R6

  AST_FIXED_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (bank[2:0] == addr[12:10] && bank[4:3] == fix_bank)); // R8

  AST_ROM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> !(rom_rd || ext_wr)); // R1
endmodule

// File: tb/test_chr_bank_xlat.sv
module test_chr_bank_xlat;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic ram_en = 0, outer_a = 0, outer_b = 0, outer_top = 0, ser_4kb = 0;
  logic [7:0] m0_bank = 0;
  logic [4:0] ser_bank0 = 0, ser_bank1 = 0;
  logic [1:0] fix_bank = 0;
  logic [12:0] addr = 0;
  logic rd = 0, wr = 0;
  logic [7:0] wdata = 0;
  logic [17:0] bank;
  logic [9:0] offset;
  logic rom_rd, ext_wr;
  logic [7:0] rdata;

  int checks = 0, errors = 0;
  bit done = 0;
  byte unsigned model_mem [int];
  int exp_rdata = 0;
  bit exp_known = 1;

  chr_bank_xlat i_chr_bank_xlat (
    .clk, .rst_n, .mode, .ram_en, .outer_a, .outer_b, .outer_top, .m0_bank,
    .ser_4kb, .ser_bank0, .ser_bank1, .fix_bank, .addr, .rd, .wr, .wdata,
    .bank, .offset, .rom_rd, .ext_wr, .rdata);

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_rdata = 0; exp_known = 1;
    end else begin
      if (rd && ram_en) begin
        if (model_mem.exists(int'(addr))) begin
          exp_rdata = model_mem[int'(addr)]; exp_known = 1;
        end else exp_known = 0;
      end
      if (wr && ram_en) model_mem[int'(addr)] = wdata;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int expected_bank(output string tag);
    int win8 = (int'(addr) >> 10) % 8;
    int win4 = (int'(addr) >> 10) % 4;
    int outer1k = outer_top * 131072 + outer_b * 65536 + outer_a * 32768;
    int outer8k = outer_top * 16384 + outer_b * 8192 + outer_a * 4096;
    int sel;
    case (mode)
      0: begin tag = "R3,R4"; return outer1k + m0_bank; end
      1: if (!ser_4kb) begin
           tag = "R3,R5"; return outer1k + (ser_bank0 & 30) * 4 + win8;
         end else begin
           tag = "R3,R6"; sel = addr[12] ? ser_bank1 : ser_bank0;
           return outer1k + sel * 4 + win4;
         end
      2: begin tag = "R3,R7"; return outer1k + win8; end
      default: begin tag = "R3,R8"; return (outer8k + fix_bank) * 8 + win8; end
    endcase
  endfunction

  always @(negedge clk) begin
    string tag;
    int eb;
    if (!done) begin
      eb = expected_bank(tag);
      check(tag, int'(bank), eb);
      check("R9 offset", int'(offset), int'(addr) % 1024);
      check(ram_en ? "R1 rom_rd" : "R10 rom_rd", int'(rom_rd), ram_en ? 0 : int'(rd));
      check(ram_en ? "R1 ext_wr" : "R10 ext_wr", int'(ext_wr), ram_en ? 0 : int'(wr));
      if (exp_known) check("R2 rdata", int'(rdata), exp_rdata);
    end
  end

  task automatic step(bit r, bit w, int a, int d);
    @(posedge clk); #1;
    rd = r; wr = w; addr = 13'(a); wdata = 8'(d);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; check("R11 reset rdata", int'(rdata), 0);
    rst_n = 1;
    @(negedge clk); check("R11 after release", int'(rdata), 0);

    ram_en = 1;
    step(0, 1, 'h0000, 'hA5);
    step(0, 1, 'h1FFF, 'h5A);
    step(0, 1, 'h0400, 'h3C);
    step(1, 0, 'h0000, 0);
    step(1, 0, 'h1FFF, 0);
    step(1, 0, 'h0400, 0);
    step(1, 1, 'h0000, 'h11);   // R2 old data on same-cycle read/write
    step(1, 0, 'h0000, 0);
    step(0, 0, 'h0000, 0);
    ram_en = 0;
    step(0, 1, 'h0400, 'hFF);   // R10 write must not reach RAM
    ram_en = 1;
    step(1, 0, 'h0400, 0);
    step(0, 0, 0, 0);

    ram_en = 0; rd = 1;
    for (int m = 0; m < 4; m++) begin
      for (int g = 0; g < 2; g++) begin
        for (int w = 0; w < 8; w++) begin
          @(posedge clk); #1;
          mode = 2'(m); ser_4kb = g[0];
          ser_bank0 = 5'h13; ser_bank1 = 5'h0A; fix_bank = 2'(w);
          m0_bank = 8'(8'hC0 + w); {outer_top, outer_b, outer_a} = 3'(w);
          addr = 13'(w * 'h400 + w * 7);
        end
      end
    end

    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #1;
      mode = 2'($urandom); ram_en = 1'($urandom); ser_4kb = 1'($urandom);
      {outer_top, outer_b, outer_a} = 3'($urandom);
      m0_bank = 8'($urandom); ser_bank0 = 5'($urandom); ser_bank1 = 5'($urandom);
      fix_bank = 2'($urandom); addr = 13'($urandom % 64 * 128 + $urandom % 3);
      rd = 1'($urandom); wr = 1'($urandom); wdata = 8'($urandom);
    end

    step(0, 0, 0, 0);
    @(negedge clk); #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule